// File: doc/BRIEF.md
# Multi-Plane Page Read Pipeline

This block streams bytes from the page caches of up to four planes to a byte-wide output. A burst begins with a start pulse, which loads a start column and a mask of the planes taking part. After that, each read-strobe event moves the whole path forward by one step. The strobe is a one-cycle qualifier that the surrounding logic raises once per output event. In the slow mode that is one event per I/O cycle; in the double-rate mode there is one event for each strobe edge. The path is the same in both modes, so the block has no mode input.

The path has three registered stages, and each stage moves only on a strobe event. Stage one holds the column and plane taken from the running counter, and it drives the word address to the caches. Stage two captures a four-byte word from every plane's cache. It does this only when a new word is needed: on the first byte of a burst, or when the low two column bits return to zero. Stage three selects the plane, then the byte within the word, and registers the result as the output byte. When the counter passes the last column of a page, it moves to column zero of the next plane enabled in the mask.

Top module: `plane_read_pipe`

## Requirements
- R1: After reset `dataValid` is 0 and `fetchStrobe` is 0, and strobes issued before any start produce no output byte.
- R2: A start with a non-empty mask begins at column `startCol` of the lowest-numbered plane set in `planeMask`; the first output byte is that byte.
- R3: The first `dataValid` of a burst appears in the cycle after the third strobe event following the start; the first and second strobe events produce no valid byte.
- R4: Every later strobe event yields exactly one valid byte in the following cycle. A cycle without a strobe yields `dataValid` = 0 and loses no byte, so the byte order continues unbroken when strobes resume.
- R5: The column rises by one for each byte. Byte b of a cache word (b = column mod 4) sits at bits 8b+7..8b of that plane's 32-bit slice, and plane p's slice is bits 32p+31..32p of `cacheData`.
- R6: `fetchStrobe` is high, together with a strobe event, exactly when stage one holds a valid byte that is either the first byte of the burst or has column mod 4 = 0. While it is high, `wordAddr` equals that column divided by 4.
- R7: After the last column of a page (PAGE_BYTES-1), the next byte is column 0 of the next higher plane set in the mask. The search wraps circularly to the lowest set plane, and a single-plane mask returns to its own plane.
- R8: `abortBurst` clears `dataValid` on the next clock and ends the burst, so no byte or fetch follows until the next start. It takes priority over a start and a strobe in the same cycle.
- R9: A start with an all-zero mask ends any running burst, and no byte is produced afterwards.
- R10: A start during a running burst flushes the pipeline (`dataValid` is 0 in the next cycle), and the new burst again observes the latency of R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startBurst | input | 1 | Loads start column and plane mask, begins a burst |
| startCol | input | COL_W | First column of the burst |
| planeMask | input | NUM_PLANES | Planes taking part in the burst |
| readStrobe | input | 1 | One output event; advances the pipeline |
| abortBurst | input | 1 | Flushes the pipeline and ends the burst |
| cacheData | input | NUM_PLANES*32 | Word at `wordAddr` from every plane cache |
| wordAddr | output | COL_W-2 | Word address of the byte in stage one |
| fetchStrobe | output | 1 | Stage two captures `cacheData` at this edge |
| dataOut | output | 8 | Output byte |
| dataValid | output | 1 | `dataOut` holds a new byte this cycle |

## Verification
The assertions assume that `startCol` is below PAGE_BYTES and that the cache presents, within the same cycle, the word addressed by `wordAddr`. They also assume that abort, start and strobe are sampled only at clock edges. The stimulus meets these conditions through a combinational cache model that computes each byte from its plane and column. Start columns are swept only across the page, and every input changes on the falling edge. The strobe gap patterns are periodic and never stop the strobe entirely, so each burst reaches the strobe count it asks for.

// File: rtl/plane_read_pkg.sv
package plane_read_pkg;

  localparam int BYTE_W     = 8;
  localparam int WORD_BYTES = 4;
  localparam int WORD_W     = BYTE_W * WORD_BYTES;

  // Strobes from control to datapath for one clock edge.
  typedef struct packed {
    logic advance;  // all stages move one step
    logic fetch;    // stage two captures fresh cache words
  } pipeStb_t;

endpackage

// File: rtl/plane_read_ctrl.sv
module plane_read_ctrl
  import plane_read_pkg::*;
#(
  parameter int NUM_PLANES = 4,
  parameter int PAGE_BYTES = 64,
  localparam int COL_W = $clog2(PAGE_BYTES),
  localparam int PL_W  = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  startBurst,
  input  logic [COL_W-1:0]      startCol,
  input  logic [NUM_PLANES-1:0] planeMask,
  input  logic                  readStrobe,
  input  logic                  abortBurst,
  output pipeStb_t              stb,
  output logic [COL_W-1:0]      s1Col,
  output logic [PL_W-1:0]       s1Plane,
  output logic                  dataValid
);

  localparam logic [COL_W-1:0] LAST_COL = COL_W'(PAGE_BYTES - 1);

  logic                  active;
  logic                  firstPending;
  logic                  s1Valid;
  logic                  s1First;
  logic                  s2Valid;
  logic                  outValid;
  logic [NUM_PLANES-1:0] maskReg;
  logic [COL_W-1:0]      nextCol;
  logic [PL_W-1:0]       nextPlane;

  function automatic logic [PL_W-1:0] lowestSet(input logic [NUM_PLANES-1:0] m);
    lowestSet = '0;
    for (int i = NUM_PLANES - 1; i >= 0; i--) begin
      if (m[i]) lowestSet = PL_W'(i);
    end
  endfunction

  // Next enabled plane after cur, searching circularly; cur itself if alone.
  function automatic logic [PL_W-1:0] followingSet(input logic [NUM_PLANES-1:0] m,
                                                   input logic [PL_W-1:0] cur);
    followingSet = cur;
    for (int k = NUM_PLANES - 1; k >= 1; k--) begin
      if (m[(int'(cur) + k) % NUM_PLANES]) followingSet = PL_W'((int'(cur) + k) % NUM_PLANES);
    end
  endfunction

  always_comb begin
    stb.advance = readStrobe & ~abortBurst & ~startBurst;
    stb.fetch   = stb.advance & s1Valid & (s1First | (s1Col[1:0] == 2'd0));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      active       <= 1'b0;
      firstPending <= 1'b0;
      s1Valid      <= 1'b0;
      s1First      <= 1'b0;
      s2Valid      <= 1'b0;
      outValid     <= 1'b0;
      maskReg      <= '0;
      nextCol      <= '0;
      nextPlane    <= '0;
      s1Col        <= '0;
      s1Plane      <= '0;
    end else if (abortBurst) begin
      active       <= 1'b0;
      firstPending <= 1'b0;
      s1Valid      <= 1'b0;
      s2Valid      <= 1'b0;
      outValid     <= 1'b0;
    end else if (startBurst) begin
      s1Valid  <= 1'b0;
      s2Valid  <= 1'b0;
      outValid <= 1'b0;
      if (|planeMask) begin
        active       <= 1'b1;
        firstPending <= 1'b1;
        maskReg      <= planeMask;
        nextCol      <= startCol;
        nextPlane    <= lowestSet(planeMask);
      end else begin
        active       <= 1'b0;
        firstPending <= 1'b0;
      end
    end else if (readStrobe) begin
      outValid <= s2Valid;
      s2Valid  <= s1Valid;
      s1Valid  <= active;
      if (active) begin
        s1Col        <= nextCol;
        s1Plane      <= nextPlane;
        s1First      <= firstPending;
        firstPending <= 1'b0;
        if (nextCol == LAST_COL) begin
          nextCol   <= '0;
          nextPlane <= followingSet(maskReg, nextPlane);
        end else begin
          nextCol <= nextCol + 1'b1;
        end
      end
    end else begin
      outValid <= 1'b0;
    end
  end

  assign dataValid = outValid;

  AST_VALID_NEEDS_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    dataValid |-> $past(readStrobe)); // R4

  AST_ABORT_CLEARS: assert property (@(posedge clk) disable iff (!rstN)
    abortBurst |=> !dataValid); // R8

  AST_PLANE_ENABLED: assert property (@(posedge clk) disable iff (!rstN)
    active |-> maskReg[nextPlane]); // R7

  AST_EMPTY_MASK_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    (startBurst && !abortBurst && planeMask == '0) |=> !dataValid); // R9

endmodule

// File: rtl/plane_read_dp.sv
module plane_read_dp
  import plane_read_pkg::*;
#(
  parameter int NUM_PLANES = 4,
  localparam int PL_W = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  pipeStb_t                     stb,
  input  logic [1:0]                   s1ByteSel,
  input  logic [PL_W-1:0]              s1Plane,
  input  logic [NUM_PLANES*WORD_W-1:0] cacheData,
  output logic [BYTE_W-1:0]            dataOut
);

  logic [WORD_W-1:0] wordReg [NUM_PLANES];
  logic [1:0]        s2ByteSel;
  logic [PL_W-1:0]   s2Plane;
  logic [WORD_W-1:0] planeWord;
  logic [BYTE_W-1:0] byteSel;

  // Stage two: second sense of every plane's cache word.
  for (genvar g = 0; g < NUM_PLANES; g++) begin : g_plane
    always_ff @(posedge clk) begin
      if (!rstN)          wordReg[g] <= '0;
      else if (stb.fetch) wordReg[g] <= cacheData[g*WORD_W +: WORD_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      s2ByteSel <= '0;
      s2Plane   <= '0;
    end else if (stb.advance) begin
      s2ByteSel <= s1ByteSel;
      s2Plane   <= s1Plane;
    end
  end

  // Stage three: plane mux, then byte mux next to the port.
  always_comb begin
    planeWord = wordReg[s2Plane];
    byteSel   = planeWord[s2ByteSel*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rstN)            dataOut <= '0;
    else if (stb.advance) dataOut <= byteSel;
  end

  AST_HOLD_WITHOUT_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !stb.advance |=> $stable(dataOut)); // R4

endmodule

// File: rtl/plane_read_pipe.sv
module plane_read_pipe
  import plane_read_pkg::*;
#(
  parameter int NUM_PLANES = 4,
  parameter int PAGE_BYTES = 64,
  localparam int COL_W = $clog2(PAGE_BYTES),
  localparam int PL_W  = (NUM_PLANES > 1) ? $clog2(NUM_PLANES) : 1
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         startBurst,
  input  logic [COL_W-1:0]             startCol,
  input  logic [NUM_PLANES-1:0]        planeMask,
  input  logic                         readStrobe,
  input  logic                         abortBurst,
  input  logic [NUM_PLANES*WORD_W-1:0] cacheData,
  output logic [COL_W-3:0]             wordAddr,
  output logic                         fetchStrobe,
  output logic [BYTE_W-1:0]            dataOut,
  output logic                         dataValid
);

  pipeStb_t         stb;
  logic [COL_W-1:0] s1Col;
  logic [PL_W-1:0]  s1Plane;

  plane_read_ctrl #(
    .NUM_PLANES(NUM_PLANES),
    .PAGE_BYTES(PAGE_BYTES)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .startBurst (startBurst),
    .startCol   (startCol),
    .planeMask  (planeMask),
    .readStrobe (readStrobe),
    .abortBurst (abortBurst),
    .stb        (stb),
    .s1Col      (s1Col),
    .s1Plane    (s1Plane),
    .dataValid  (dataValid)
  );

  plane_read_dp #(
    .NUM_PLANES(NUM_PLANES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .stb       (stb),
    .s1ByteSel (s1Col[1:0]),
    .s1Plane   (s1Plane),
    .cacheData (cacheData),
    .dataOut   (dataOut)
  );

  assign wordAddr    = s1Col[COL_W-1:2];
  assign fetchStrobe = stb.fetch;

  AST_FETCH_ON_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    fetchStrobe |-> readStrobe && !abortBurst); // R6

endmodule

// File: tb/plane_read_pipe_bench.sv
`timescale 1ns/100ps
module plane_read_pipe_bench;

  localparam int NP = 4;
  localparam int PG = 16;
  localparam int CW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          startBurst = 1'b0;
  logic          readStrobe = 1'b0;
  logic          abortBurst = 1'b0;
  logic [CW-1:0] startCol = '0;
  logic [NP-1:0] planeMask = '0;
  logic [NP*32-1:0] cacheData;
  logic [CW-3:0] wordAddr;
  logic          fetchStrobe;
  logic [7:0]    dataOut;
  logic          dataValid;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  int seqP [64];
  int seqC [64];

  plane_read_pipe #(.NUM_PLANES(NP), .PAGE_BYTES(PG)) u_plane_read_pipe (
    .clk(clk), .rstN(rstN), .startBurst(startBurst), .startCol(startCol),
    .planeMask(planeMask), .readStrobe(readStrobe), .abortBurst(abortBurst),
    .cacheData(cacheData), .wordAddr(wordAddr), .fetchStrobe(fetchStrobe),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  always #2.5 clk = ~clk;

  function automatic logic [7:0] patByte(input int p, input int c);
    return 8'((p * 53 + c * 11 + 5) & 255);
  endfunction

  // Cache model: every plane returns the word at wordAddr.
  always_comb begin
    for (int p = 0; p < NP; p++)
      for (int b = 0; b < 4; b++)
        cacheData[p*32 + b*8 +: 8] = patByte(p, int'(wordAddr) * 4 + b);
  end

  function automatic int lowPlane(input int m);
    for (int i = 0; i < NP; i++) if (m[i]) return i;
    return 0;
  endfunction

  function automatic int nextPlane(input int m, input int cur);
    for (int k = 1; k < NP; k++) if (m[(cur + k) % NP]) return (cur + k) % NP;
    return cur;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runBurst(input int mask, input int sc, input int nStr, input int gm);
    int n;
    int k;
    int i;
    bit s;
    bit expF;
    bit expV;
    @(negedge clk);
    startBurst = 1'b1; planeMask = NP'(mask); startCol = CW'(sc); readStrobe = 1'b0;
    @(posedge clk); #1;
    check(dataValid == 1'b0, "R10 flush on start", int'(dataValid), 0);
    @(negedge clk);
    startBurst = 1'b0;
    seqP[0] = lowPlane(mask);
    seqC[0] = sc;
    for (int j = 1; j < nStr; j++) begin
      seqC[j] = seqC[j-1] + 1;
      seqP[j] = seqP[j-1];
      if (seqC[j] == PG) begin
        seqC[j] = 0;
        seqP[j] = nextPlane(mask, seqP[j-1]);
      end
    end
    n = 0; k = 0; i = 0;
    while (n < nStr) begin
      s = (gm == 0) || ((i % gm) != gm - 1);
      i++;
      readStrobe = s;
      #1;
      expF = s && n >= 1 && (n == 1 || (seqC[n-1] % 4) == 0);
      check(fetchStrobe == expF, "R6 fetch", int'(fetchStrobe), int'(expF));
      if (expF) check(int'(wordAddr) == seqC[n-1] / 4, "R6 wordAddr", int'(wordAddr), seqC[n-1] / 4);
      @(posedge clk); #1;
      if (s) n++;
      expV = s && n >= 3;
      if (s) check(dataValid == expV, "R3 latency", int'(dataValid), int'(expV));
      else   check(dataValid == 1'b0, "R4 gap", int'(dataValid), 0);
      if (dataValid && expV) begin
        if (k == 0)
          check(dataOut == patByte(seqP[k], seqC[k]), "R2 first byte", int'(dataOut), int'(patByte(seqP[k], seqC[k])));
        else if (seqC[k] == 0)
          check(dataOut == patByte(seqP[k], seqC[k]), "R7 page wrap", int'(dataOut), int'(patByte(seqP[k], seqC[k])));
        else
          check(dataOut == patByte(seqP[k], seqC[k]), "R5 byte", int'(dataOut), int'(patByte(seqP[k], seqC[k])));
        k++;
      end
      @(negedge clk);
    end
    readStrobe = 1'b0;
  endtask

  task automatic expectSilent(input int cycles, input string req);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      readStrobe = 1'b1;
      #1;
      check(fetchStrobe == 1'b0, req, int'(fetchStrobe), 0);
      @(posedge clk); #1;
      check(dataValid == 1'b0, req, int'(dataValid), 0);
    end
    @(negedge clk);
    readStrobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    #1;
    check(dataValid == 1'b0, "R1 reset valid", int'(dataValid), 0);
    check(fetchStrobe == 1'b0, "R1 reset fetch", int'(fetchStrobe), 0);
    expectSilent(5, "R1 strobe before start");

    // Sweep: every mask, every start column, three strobe gap patterns.
    for (int m = 1; m < (1 << NP); m++) begin
      for (int sc = 0; sc < PG; sc++) begin
        runBurst(m, sc, 24, (sc % 3 == 0) ? 0 : ((sc % 3 == 1) ? 3 : 5));
      end
    end

    // Abort mid-burst, with a strobe in the same cycle.
    runBurst(4'b0101, 14, 6, 0);
    @(negedge clk);
    abortBurst = 1'b1; readStrobe = 1'b1;
    @(posedge clk); #1;
    check(dataValid == 1'b0, "R8 abort clears valid", int'(dataValid), 0);
    @(negedge clk);
    abortBurst = 1'b0; readStrobe = 1'b0;
    expectSilent(6, "R8 nothing after abort");

    // Abort beats a simultaneous start.
    @(negedge clk);
    abortBurst = 1'b1; startBurst = 1'b1; planeMask = 4'b1111; startCol = '0;
    @(posedge clk); #1;
    check(dataValid == 1'b0, "R8 abort over start", int'(dataValid), 0);
    @(negedge clk);
    abortBurst = 1'b0; startBurst = 1'b0;
    expectSilent(6, "R8 abort over start");

    // Empty mask stops a running burst.
    runBurst(4'b0011, 3, 6, 0);
    @(negedge clk);
    startBurst = 1'b1; planeMask = '0;
    @(posedge clk); #1;
    check(dataValid == 1'b0, "R9 empty mask", int'(dataValid), 0);
    @(negedge clk);
    startBurst = 1'b0;
    expectSilent(6, "R9 empty mask");

    // Recovery after abort and empty mask.
    runBurst(4'b1000, 7, 20, 3);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule